// File: doc/BRIEF.md
# Vector-Config Micro-op Expander

This block sits behind the decoder of a vector-capable core. It accepts one decoded vector-configuration instruction at a time. The instruction is one of three forms: register-length, register-type, or immediate-only. It arrives with its rs1 and rd register indices. The block expands it into an ordered list of one or two micro-ops. Each micro-op carries an 8-bit operation code together with source-read flags and a destination class. The destination is the integer register rd, the vector configuration state, or a scratch vector register. The execution units that compute the vector length downstream decode the operation-code bits directly.

Sequence selection depends only on the instruction form and on whether rs1 and rd name register zero. Length and limit arithmetic are not done here, and no register file is accessed. Micro-ops leave over a valid/ready port. The instruction stays held inside the block until its final micro-op is taken. A flush input drops whatever remains of the current list.

Top module: `vcx_expander`

## Requirements
- R1: After reset, uop_valid is 0 and in_ready is 1.
- R2: in_ready is 1 exactly when no list is in progress. An instruction accepted with in_valid and in_ready is presented as a micro-op in the following cycle. Form encoding on in_kind: 00 immediate form, 01 register-length form, 10 register-type form, 11 treated as the immediate form.
- R3: Register-length form, rs1 not zero: the block emits 0xA0 and then 0x80, both with uop_rd_rs1=1. The destination is configuration, then integer.
- R4: Register-length form, rs1 zero, rd not zero: the block emits 0xA1 and then 0x81, with no source flag set. The destinations are configuration, then integer.
- R5: Register-length form, rs1 and rd zero: the block emits the single micro-op 0xA2 with uop_rd_cfg=1 and destination configuration.
- R6: Register-type form, rs1 not zero: the block emits 0x60 and then 0x40, both with uop_rd_rs1=1 and uop_rd_rs2=1. The destinations are configuration, then integer.
- R7: Register-type form, rs1 zero, rd not zero: the block emits 0x61 and then 0x41, both with only uop_rd_rs2=1. The destinations are configuration, then integer.
- R8: Register-type form, rs1 and rd zero: the block first emits 0x62 with uop_rd_rs2=1 and destination scratch. It then emits 0x72 with uop_rd_cfg=1, uop_rd_tmp=1 and destination configuration.
- R9: Immediate form: the block emits 0x20 and then 0x00 with no source flag, whatever the rs1 and rd values. The destinations are configuration, then integer.
- R10: While uop_valid is 1 and uop_ready is 0, and flush is low, the presented micro-op and all its fields stay unchanged.
- R11: In every two-micro-op list whose first micro-op writes configuration, the second code equals the first with bit 5 inverted.
- R12: A flush makes uop_valid 0 and in_ready 1 in the next cycle. A flush in an idle cycle blocks acceptance in that cycle.
- R13: uop_last is 1 only on the final micro-op of a list. Destination encoding on uop_dest: 0 integer, 1 configuration, 2 scratch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Abort the remaining micro-ops |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle, instruction can be taken |
| in_kind | input | 2 | Instruction form |
| in_rs1 | input | 5 | rs1 index |
| in_rd | input | 5 | rd index |
| uop_valid | output | 1 | Micro-op presented |
| uop_ready | input | 1 | Consumer takes the micro-op |
| uop_code | output | 8 | Micro-op operation code |
| uop_rd_rs1 | output | 1 | Reads integer rs1 |
| uop_rd_rs2 | output | 1 | Reads integer rs2 |
| uop_rd_cfg | output | 1 | Reads the old configuration |
| uop_rd_tmp | output | 1 | Reads the scratch vector register |
| uop_dest | output | 2 | Destination class |
| uop_last | output | 1 | Final micro-op of the list |

## Verification
The first micro-op is due one cycle after the edge that accepts the instruction. Each later micro-op is due one cycle after the edge on which its predecessor is taken. in_ready returns one cycle after the last micro-op is taken or after a flush. The scoreboard queues the expected micro-ops when the instruction is driven. It compares each one only at a negative edge where both uop_valid and uop_ready are high, so the varying ready pattern never shifts the comparison. Stall cycles are checked separately against the value seen one edge earlier. The flush checks sample the outputs at the first negative edge after the flush edge.

// File: rtl/vcx_pkg.sv
package vcx_pkg;

    localparam int CODE_W  = 8;
    localparam int IDX_W   = 5;
    localparam int MAX_UOP = 2;
    localparam int CNT_W   = $clog2(MAX_UOP);

    // bit positions decoded by downstream units
    localparam int B_VLMAX = 0;
    localparam int B_KEEP  = 1;
    localparam int B_VREG  = 4;
    localparam int B_CFG   = 5;

    typedef enum logic [1:0] {
        FORM_IMM  = 2'b00,
        FORM_LEN  = 2'b01,
        FORM_TYPE = 2'b10,
        FORM_RSV  = 2'b11
    } form_e;

    typedef enum logic [1:0] {
        DST_INT = 2'd0,
        DST_CFG = 2'd1,
        DST_TMP = 2'd2
    } dest_e;

    typedef struct packed {
        logic  rd_rs1;
        logic  rd_rs2;
        logic  rd_cfg;
        logic  rd_tmp;
        dest_e dest;
    } uop_info_t;

    typedef struct packed {
        logic [CNT_W-1:0]  last_idx;
        logic [CODE_W-1:0] code1;
        logic [CODE_W-1:0] code0;
    } uop_list_t;

    // assemble an operation code from its meaningful bits
    function automatic logic [CODE_W-1:0] make_code(
        input logic [1:0] fam, input logic cfg, input logic vreg,
        input logic keep, input logic vlmax);
        logic [CODE_W-1:0] c;
        c = '0;
        c[7:6]     = fam;
        c[B_CFG]   = cfg;
        c[B_VREG]  = vreg;
        c[B_KEEP]  = keep;
        c[B_VLMAX] = vlmax;
        return c;
    endfunction

    function automatic logic [CODE_W-1:0] to_int_dest(input logic [CODE_W-1:0] c);
        return c ^ (CODE_W'(1) << B_CFG);
    endfunction

endpackage

// File: rtl/vcx_seq_select.sv
module vcx_seq_select
    import vcx_pkg::*;
#(
    parameter int REG_W = IDX_W
) (
    input  logic [1:0]       kind,
    input  logic [REG_W-1:0] rs1,
    input  logic [REG_W-1:0] rd,
    output uop_list_t        list
);
    localparam logic [1:0] FAM_LEN  = 2'b10;
    localparam logic [1:0] FAM_TYPE = 2'b01;
    localparam logic [1:0] FAM_IMM  = 2'b00;

    logic rs1_zero, rd_zero;
    logic [CODE_W-1:0] first;

    assign rs1_zero = (rs1 == '0);
    assign rd_zero  = (rd == '0);

    always_comb begin
        first         = '0;
        list.code0    = '0;
        list.code1    = '0;
        list.last_idx = CNT_W'(1);
        unique case (form_e'(kind))
            FORM_LEN: begin
                if (!rs1_zero) begin
                    first = make_code(FAM_LEN, 1'b1, 1'b0, 1'b0, 1'b0);
                end else if (!rd_zero) begin
                    first = make_code(FAM_LEN, 1'b1, 1'b0, 1'b0, 1'b1);
                end else begin
                    first = make_code(FAM_LEN, 1'b1, 1'b0, 1'b1, 1'b0);
                    list.last_idx = CNT_W'(0);
                end
                list.code0 = first;
                list.code1 = to_int_dest(first);
            end
            FORM_TYPE: begin
                if (!rs1_zero) begin
                    first = make_code(FAM_TYPE, 1'b1, 1'b0, 1'b0, 1'b0);
                    list.code1 = to_int_dest(first);
                end else if (!rd_zero) begin
                    first = make_code(FAM_TYPE, 1'b1, 1'b0, 1'b0, 1'b1);
                    list.code1 = to_int_dest(first);
                end else begin
                    // move rs2 into scratch, then merge with the old length
                    first = make_code(FAM_TYPE, 1'b1, 1'b0, 1'b1, 1'b0);
                    list.code1 = make_code(FAM_TYPE, 1'b1, 1'b1, 1'b1, 1'b0);
                end
                list.code0 = first;
            end
            default: begin
                first      = make_code(FAM_IMM, 1'b1, 1'b0, 1'b0, 1'b0);
                list.code0 = first;
                list.code1 = to_int_dest(first);
            end
        endcase
    end

endmodule

// File: rtl/vcx_uop_annot.sv
module vcx_uop_annot
    import vcx_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output uop_info_t         info
);
    logic is_len, is_type, normal, keep, vreg, cfg;

    assign is_len  = code[7];
    assign is_type = code[6];
    assign normal  = (code[B_KEEP:B_VLMAX] == 2'b00);
    assign keep    = code[B_KEEP];
    assign vreg    = code[B_VREG];
    assign cfg     = code[B_CFG];

    always_comb begin
        info.rd_rs1 = (is_len || is_type) && normal;
        info.rd_rs2 = is_type && !vreg;
        info.rd_tmp = vreg;
        info.rd_cfg = keep && !(is_type && !vreg);
        if (is_type && keep && !vreg)
            info.dest = DST_TMP;
        else if (cfg)
            info.dest = DST_CFG;
        else
            info.dest = DST_INT;
    end

endmodule

// File: rtl/vcx_issue_fsm.sv
module vcx_issue_fsm
    import vcx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              in_valid,
    input  uop_list_t         list_in,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CODE_W-1:0] out_code,
    output logic              out_last
);
    typedef enum logic {S_IDLE, S_ISSUE} st_e;

    st_e               st_q;
    logic [CNT_W-1:0]  idx_q;
    logic [CNT_W-1:0]  last_q;
    logic [CODE_W-1:0] slot_q [MAX_UOP];
    logic [CODE_W-1:0] slot_in [MAX_UOP];

    assign slot_in[0] = list_in.code0;
    assign slot_in[1] = list_in.code1;

    logic take, pop;
    assign in_ready  = (st_q == S_IDLE);
    assign take      = in_valid && in_ready && !flush;
    assign out_valid = (st_q == S_ISSUE);
    assign pop       = out_valid && out_ready;
    assign out_code  = slot_q[idx_q];
    assign out_last  = (idx_q == last_q);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            st_q  <= S_IDLE;
            idx_q <= '0;
        end else if (take) begin
            st_q  <= S_ISSUE;
            idx_q <= '0;
        end else if (pop) begin
            if (out_last) begin
                st_q  <= S_IDLE;
                idx_q <= '0;
            end else begin
                idx_q <= idx_q + CNT_W'(1);
            end
        end
    end

    generate
        for (genvar g = 0; g < MAX_UOP; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)       slot_q[g] <= '0;
                else if (take) slot_q[g] <= slot_in[g];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)       last_q <= '0;
        else if (take) last_q <= list_in.last_idx;
    end

endmodule

// File: rtl/vcx_expander.sv
module vcx_expander
    import vcx_pkg::*;
#(
    parameter int REG_W = IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [1:0]       in_kind,
    input  logic [REG_W-1:0] in_rs1,
    input  logic [REG_W-1:0] in_rd,
    output logic             uop_valid,
    input  logic             uop_ready,
    output logic [7:0]       uop_code,
    output logic             uop_rd_rs1,
    output logic             uop_rd_rs2,
    output logic             uop_rd_cfg,
    output logic             uop_rd_tmp,
    output logic [1:0]       uop_dest,
    output logic             uop_last
);
    uop_list_t list;
    uop_info_t info;

    vcx_seq_select #(.REG_W(REG_W)) u_sel (
        .kind (in_kind),
        .rs1  (in_rs1),
        .rd   (in_rd),
        .list (list)
    );

    vcx_issue_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .in_valid  (in_valid),
        .list_in   (list),
        .in_ready  (in_ready),
        .out_valid (uop_valid),
        .out_ready (uop_ready),
        .out_code  (uop_code),
        .out_last  (uop_last)
    );

    vcx_uop_annot u_annot (
        .code (uop_code),
        .info (info)
    );

    assign uop_rd_rs1 = info.rd_rs1;
    assign uop_rd_rs2 = info.rd_rs2;
    assign uop_rd_cfg = info.rd_cfg;
    assign uop_rd_tmp = info.rd_tmp;
    assign uop_dest   = info.dest;

endmodule

// File: rtl/vcx_expander_chk.sv
module vcx_expander_chk (
    input logic       clk,
    input logic       rst,
    input logic       flush,
    input logic       in_valid,
    input logic       in_ready,
    input logic       uop_valid,
    input logic       uop_ready,
    input logic [7:0] uop_code,
    input logic       uop_rd_rs2,
    input logic [1:0] uop_dest,
    input logic       uop_last
);
    // R2: no acceptance while a list is being issued
    a_r2_ready_idle: assert property (@(posedge clk) disable iff (rst)
        uop_valid |-> !in_ready);

    // R2: acceptance leads to a micro-op next cycle
    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !flush) |=> uop_valid);

    // R10: stalled micro-op holds
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && !uop_ready && !flush) |=> (uop_valid && $stable(uop_code) && $stable(uop_last)));

    // R11: second of a pair is the first with bit 5 toggled
    a_r11_toggle: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && uop_ready && !uop_last && uop_dest == 2'd1 && !flush)
        |=> (uop_valid && uop_code == ($past(uop_code) ^ 8'h20)));

    // R12: flush empties the output
    a_r12_flush: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!uop_valid && in_ready));

    // R5 / R13: the keep-length register-length micro-op stands alone
    a_r5_single: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && uop_code == 8'hA2) |-> uop_last);

    // R8: the scratch move reads rs2 and is never final
    a_r8_tmp_first: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && uop_dest == 2'd2) |-> (uop_rd_rs2 && !uop_last));

endmodule

bind vcx_expander vcx_expander_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .uop_valid  (uop_valid),
    .uop_ready  (uop_ready),
    .uop_code   (uop_code),
    .uop_rd_rs2 (uop_rd_rs2),
    .uop_dest   (uop_dest),
    .uop_last   (uop_last)
);

// File: tb/vcx_expander_tb.sv
module vcx_expander_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       flush = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [1:0] in_kind = 2'b00;
    logic [4:0] in_rs1 = '0;
    logic [4:0] in_rd = '0;
    logic       uop_valid;
    logic       uop_ready = 1'b0;
    logic [7:0] uop_code;
    logic       uop_rd_rs1, uop_rd_rs2, uop_rd_cfg, uop_rd_tmp;
    logic [1:0] uop_dest;
    logic       uop_last;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit stall_all = 0;
    int cyc = 0;

    // code[14:7], flags rs1 rs2 cfg tmp [6:3], dest [2:1], last [0]
    logic [14:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    vcx_expander u_dut (
        .clk(clk), .rst(rst), .flush(flush),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_kind(in_kind), .in_rs1(in_rs1), .in_rd(in_rd),
        .uop_valid(uop_valid), .uop_ready(uop_ready),
        .uop_code(uop_code), .uop_rd_rs1(uop_rd_rs1), .uop_rd_rs2(uop_rd_rs2),
        .uop_rd_cfg(uop_rd_cfg), .uop_rd_tmp(uop_rd_tmp),
        .uop_dest(uop_dest), .uop_last(uop_last)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push(input string tag, input logic [7:0] code, input logic [3:0] fl,
                        input logic [1:0] dst, input logic last);
        exp_q.push_back({code, fl, dst, last});
        tag_q.push_back(tag);
    endtask

    // expected lists written from the requirement table
    task automatic expect_list(input logic [1:0] kind, input logic [4:0] rs1, input logic [4:0] rd);
        if (kind == 2'b01) begin
            if (rs1 != 0) begin
                push("R3", 8'hA0, 4'b1000, 2'd1, 1'b0);
                push("R3", 8'h80, 4'b1000, 2'd0, 1'b1);
            end else if (rd != 0) begin
                push("R4", 8'hA1, 4'b0000, 2'd1, 1'b0);
                push("R4", 8'h81, 4'b0000, 2'd0, 1'b1);
            end else begin
                push("R5", 8'hA2, 4'b0010, 2'd1, 1'b1);
            end
        end else if (kind == 2'b10) begin
            if (rs1 != 0) begin
                push("R6", 8'h60, 4'b1100, 2'd1, 1'b0);
                push("R6", 8'h40, 4'b1100, 2'd0, 1'b1);
            end else if (rd != 0) begin
                push("R7", 8'h61, 4'b0100, 2'd1, 1'b0);
                push("R7", 8'h41, 4'b0100, 2'd0, 1'b1);
            end else begin
                push("R8", 8'h62, 4'b0100, 2'd2, 1'b0);
                push("R8", 8'h72, 4'b0011, 2'd1, 1'b1);
            end
        end else begin
            push("R9", 8'h20, 4'b0000, 2'd1, 1'b0);
            push("R9", 8'h00, 4'b0000, 2'd0, 1'b1);
        end
    endtask

    task automatic drive(input logic [1:0] kind, input logic [4:0] rs1, input logic [4:0] rd);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_kind  = kind;
        in_rs1   = rs1;
        in_rd    = rd;
        @(negedge clk);
        in_valid = 1'b0;
        in_kind  = 2'b00;
        in_rs1   = 5'd0;
        in_rd    = 5'd0;
    endtask

    task automatic send(input logic [1:0] kind, input logic [4:0] rs1, input logic [4:0] rd);
        expect_list(kind, rs1, rd);
        drive(kind, rs1, rd);
    endtask

    // ready pattern, changed shortly after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            uop_ready = stall_all ? 1'b0 : ((cyc % 3) != 1);
        end
    end

    // monitor: compare taken micro-ops, and watch stalls (R10)
    logic       prev_stall = 1'b0;
    logic [7:0] prev_code;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall)
                check("R10 hold", {uop_valid, uop_code}, {1'b1, prev_code});
            prev_stall = uop_valid && !uop_ready && !flush;
            prev_code  = uop_code;
            if (uop_valid && uop_ready) begin
                logic [14:0] act;
                act = {uop_code, uop_rd_rs1, uop_rd_rs2, uop_rd_cfg, uop_rd_tmp, uop_dest, uop_last};
                if (exp_q.size() == 0) begin
                    check("R2 unexpected micro-op", {17'd0, act}, 32'h0);
                end else begin
                    string t;
                    logic [14:0] e;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({t, " micro-op (R13 last, R11 pair)"}, {17'd0, act}, {17'd0, e});
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 reset", {uop_valid, in_ready}, 2'b01);

        send(2'b01, 5'd3, 5'd4);   // R3
        send(2'b01, 5'd0, 5'd7);   // R4
        send(2'b01, 5'd0, 5'd0);   // R5
        send(2'b10, 5'd9, 5'd0);   // R6
        send(2'b10, 5'd0, 5'd1);   // R7
        send(2'b10, 5'd0, 5'd0);   // R8
        send(2'b00, 5'd0, 5'd0);   // R9
        send(2'b00, 5'd31, 5'd12); // R9 fields ignored
        send(2'b11, 5'd5, 5'd0);   // R9 reserved form
        send(2'b01, 5'd31, 5'd0);  // R3 rd zero
        send(2'b10, 5'd1, 5'd31);  // R6

        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        check("R2 idle after list", {uop_valid, in_ready}, 2'b01);

        // R2 timing and R12 flush
        stall_all = 1;
        @(negedge clk);
        @(negedge clk);
        in_valid = 1'b1; in_kind = 2'b10; in_rs1 = 5'd0; in_rd = 5'd0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 micro-op one cycle after accept", {uop_valid, in_ready}, 2'b10);
        check("R8 scratch first", {uop_code, uop_dest}, {8'h62, 2'd2});
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        check("R12 flush clears", {uop_valid, in_ready}, 2'b01);

        // R12 flush in idle blocks acceptance
        flush = 1'b1; in_valid = 1'b1; in_kind = 2'b01; in_rs1 = 5'd2;
        @(negedge clk);
        flush = 1'b0; in_valid = 1'b0;
        check("R12 idle flush blocks accept", {uop_valid, in_ready}, 2'b01);

        stall_all = 0;
        send(2'b10, 5'd0, 5'd0);   // R8 after flush
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        check("R13 queue drained", exp_q.size(), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule